// File: doc/BRIEF.md
# Starvation-Aware Command Queue Scheduler

This block is the request queue at the front of a memory controller. It holds up to eight pending read or write requests. Each request carries a transaction ID, an address, a read/write flag and a one-bit chip select. One queued request is offered on the issue port at a time, and the entry is released when the downstream stage takes it.

Ordering is oldest-first, with a guard against starvation. Every occupied entry runs its own countdown timer, which is loaded when the request is accepted. The load value is normally a programmable default. A read whose ID matches an enabled quality-of-service slot loads that slot's timeout instead. When a countdown reaches zero, its entry outranks every entry whose countdown has not expired.

Two status outputs report whether any queued request targets chip 0 or chip 1.

Top module: `cmdq_sched`

## Requirements
- R1: Out of reset the queue is empty: reqReady is 1, issValid is 0, and chip0Empty and chip1Empty are both 1.
- R2: A request is accepted on a clock edge where reqValid and reqReady are both 1. reqReady is 0 exactly when all 8 entries are occupied, and reqValid is ignored while reqReady is 0. An accept and an issue may complete on the same edge.
- R3: At acceptance the entry timer loads cfgDefaultTimeout, with one exception. For a read (reqWrite=0) whose reqId equals the ID of an enabled QoS slot, the timer loads that slot's timeout instead. Slot q occupies cfgQosId[4q+3:4q], cfgQosTimeout[12q+11:12q] and cfgQosEn[q]. If both slots match, slot 0 wins. Writes always load the default.
- R4: An entry's timer counts down by one on every edge after acceptance and then holds at zero without wrapping. An entry loaded with T is therefore expired from the T-th edge after its acceptance edge.
- R5: If any queued entry has expired, the issue port shows an expired entry. Among several expired entries, the one accepted first is shown.
- R6: If no queued entry has expired, the issue port shows the entry accepted first.
- R7: issValid is 1 whenever the queue is not empty. issId, issAddr, issWrite and issChip are the stored fields of the shown entry. The entry is removed on the edge where issValid and issReady are both 1. While issReady is 0 and no new entry expires, the shown entry does not change.
- R8: chip0Empty (chip1Empty) is 1 exactly when no queued entry has chip select 0 (1).
- R9: With issReady held at 1 and the queue kept refilled, an entry loaded with timeout T is issued no later than the (T+1)-th edge after its acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgDefaultTimeout | input | 12 | Timer load value for requests without a QoS match (reset value supplied by software, typically 0xFFF) |
| cfgQosEn | input | 2 | Enable per QoS slot |
| cfgQosId | input | 8 | Match ID per QoS slot, 4 bits each |
| cfgQosTimeout | input | 24 | Timer load value per QoS slot, 12 bits each |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Queue can accept a request |
| reqId | input | 4 | Request transaction ID |
| reqAddr | input | 16 | Request address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqChip | input | 1 | Target chip select |
| issValid | output | 1 | An entry is offered |
| issReady | input | 1 | Downstream takes the offered entry |
| issId | output | 4 | ID of the offered entry |
| issAddr | output | 16 | Address of the offered entry |
| issWrite | output | 1 | Read/write flag of the offered entry |
| issChip | output | 1 | Chip select of the offered entry |
| chip0Empty | output | 1 | No queued entry targets chip 0 |
| chip1Empty | output | 1 | No queued entry targets chip 1 |

## Verification
The assertions assume that every input is at a known level once reset is released. They also assume the configuration inputs hold steady across any edge where a request is accepted, since the load check compares the timer with the default sampled on that edge. The stimulus changes configuration only while reqValid is low. It drives every input half a cycle away from the active edge. It never relies on a request being taken while reqReady is low, and it checks at the ports that such a request leaves no trace.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int Q_DEPTH = 8;
  localparam int ID_W    = 4;
  localparam int ADDR_W  = 16;
  localparam int TMR_W   = 12;
  localparam int NUM_QOS = 2;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [ADDR_W-1:0] addr;
    logic              write;
    logic              chip;
  } cq_cmd_t;

  // strobes from control to datapath
  typedef struct packed {
    logic               alloc;
    logic [Q_DEPTH-1:0] allocSel;
    logic [Q_DEPTH-1:0] issueSel;
  } cq_strobe_t;
endpackage

// File: rtl/cmdq_dpath.sv
module cmdq_dpath
  import cmdq_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  cq_strobe_t                strobe,
  input  cq_cmd_t                   reqCmd,
  input  logic [TMR_W-1:0]          cfgDefault,
  input  logic [NUM_QOS-1:0]        cfgQosEn,
  input  logic [NUM_QOS*ID_W-1:0]   cfgQosId,
  input  logic [NUM_QOS*TMR_W-1:0]  cfgQosTimeout,
  output logic [Q_DEPTH-1:0]        expired,
  output logic [Q_DEPTH-1:0]        entryChip,
  output cq_cmd_t                   issCmd
);
  localparam logic [TMR_W-1:0] TMR_ONE = 1;

  cq_cmd_t          ent   [Q_DEPTH];
  logic [TMR_W-1:0] timer [Q_DEPTH];
  logic [TMR_W-1:0] loadVal;

  // lower slot index scanned last so it overrides
  always_comb begin
    loadVal = cfgDefault;
    if (!reqCmd.write) begin
      for (int q = NUM_QOS - 1; q >= 0; q--) begin
        if (cfgQosEn[q] && (cfgQosId[q*ID_W +: ID_W] == reqCmd.id))
          loadVal = cfgQosTimeout[q*TMR_W +: TMR_W];
      end
    end
  end

  for (genvar e = 0; e < Q_DEPTH; e++) begin : g_ent
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        timer[e] <= '0;
        ent[e]   <= '0;
      end else if (strobe.alloc && strobe.allocSel[e]) begin
        timer[e] <= loadVal;
        ent[e]   <= reqCmd;
      end else if (timer[e] != '0) begin
        timer[e] <= timer[e] - TMR_ONE;
      end
    end

    assign expired[e]   = (timer[e] == '0);
    assign entryChip[e] = ent[e].chip;

    // R4: one step per cycle while running
    p_timer_step_r4: assert property (@(posedge clk) disable iff (!rstN)
      (!(strobe.alloc && strobe.allocSel[e]) && timer[e] != '0)
      |=> timer[e] == $past(timer[e]) - TMR_ONE);
    // R4: no wrap once expired
    p_timer_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
      (!(strobe.alloc && strobe.allocSel[e]) && timer[e] == '0)
      |=> timer[e] == '0);
    // R3: writes always take the default
    p_write_default_r3: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.alloc && strobe.allocSel[e] && reqCmd.write)
      |=> timer[e] == $past(cfgDefault));
  end

  always_comb begin
    issCmd = '0;
    for (int e = 0; e < Q_DEPTH; e++)
      if (strobe.issueSel[e]) issCmd = ent[e];
  end
endmodule

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl
  import cmdq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               issReady,
  input  logic [Q_DEPTH-1:0] expired,
  input  logic [Q_DEPTH-1:0] entryChip,
  output cq_strobe_t         strobe,
  output logic               reqReady,
  output logic               issValid,
  output logic               chip0Empty,
  output logic               chip1Empty
);
  logic [Q_DEPTH-1:0] valid, freeSel, liveExp, cand, win;
  // older[a][b] = entry a arrived before entry b
  logic [Q_DEPTH-1:0][Q_DEPTH-1:0] older;
  logic issueFire;

  always_comb begin
    freeSel = '0;
    for (int k = Q_DEPTH - 1; k >= 0; k--) begin
      if (!valid[k]) begin
        freeSel    = '0;
        freeSel[k] = 1'b1;
      end
    end
  end

  assign liveExp = valid & expired;
  assign cand    = (|liveExp) ? liveExp : valid;

  always_comb begin
    for (int i = 0; i < Q_DEPTH; i++) begin
      win[i] = cand[i];
      for (int j = 0; j < Q_DEPTH; j++)
        if (cand[j] && older[j][i]) win[i] = 1'b0;
    end
  end

  assign reqReady  = ~(&valid);
  assign issValid  = |valid;
  assign issueFire = issValid & issReady;

  assign strobe.alloc    = reqValid & reqReady;
  assign strobe.allocSel = freeSel;
  assign strobe.issueSel = win;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) valid <= '0;
    else valid <= (valid & ~(issueFire ? win : '0)) | (strobe.alloc ? freeSel : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      older <= '0;
    end else if (strobe.alloc) begin
      for (int a = 0; a < Q_DEPTH; a++)
        for (int b = 0; b < Q_DEPTH; b++) begin
          if (freeSel[b])      older[a][b] <= valid[a] && (a != b);
          else if (freeSel[a]) older[a][b] <= 1'b0;
        end
    end
  end

  assign chip0Empty = ~(|(valid & ~entryChip));
  assign chip1Empty = ~(|(valid & entryChip));

  // R2: a new request never lands on an occupied slot
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |-> (valid & freeSel) == '0);
  // R5/R6: exactly one entry offered when not empty
  p_single_winner_r6: assert property (@(posedge clk) disable iff (!rstN)
    issValid |-> $countones(win) == 1);
  // R5: an expired entry is preferred when one exists
  p_expired_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|liveExp) |-> (win & expired) != '0);
  // R7: an accepted entry is present on the next cycle
  p_alloc_visible_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |=> issValid);
  // R8: empty queue reports both chips empty
  p_empty_flags_r8: assert property (@(posedge clk) disable iff (!rstN)
    (valid == '0) |-> (chip0Empty && chip1Empty));
endmodule

// File: rtl/cmdq_sched.sv
module cmdq_sched
  import cmdq_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [TMR_W-1:0]          cfgDefaultTimeout,
  input  logic [NUM_QOS-1:0]        cfgQosEn,
  input  logic [NUM_QOS*ID_W-1:0]   cfgQosId,
  input  logic [NUM_QOS*TMR_W-1:0]  cfgQosTimeout,
  input  logic                      reqValid,
  output logic                      reqReady,
  input  logic [ID_W-1:0]           reqId,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic                      reqWrite,
  input  logic                      reqChip,
  output logic                      issValid,
  input  logic                      issReady,
  output logic [ID_W-1:0]           issId,
  output logic [ADDR_W-1:0]         issAddr,
  output logic                      issWrite,
  output logic                      issChip,
  output logic                      chip0Empty,
  output logic                      chip1Empty
);
  cq_strobe_t         strobe;
  cq_cmd_t            reqCmd, issCmd;
  logic [Q_DEPTH-1:0] expired, entryChip;

  assign reqCmd.id    = reqId;
  assign reqCmd.addr  = reqAddr;
  assign reqCmd.write = reqWrite;
  assign reqCmd.chip  = reqChip;

  cmdq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .issReady(issReady),
    .expired(expired), .entryChip(entryChip), .strobe(strobe),
    .reqReady(reqReady), .issValid(issValid),
    .chip0Empty(chip0Empty), .chip1Empty(chip1Empty)
  );

  cmdq_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqCmd(reqCmd),
    .cfgDefault(cfgDefaultTimeout), .cfgQosEn(cfgQosEn), .cfgQosId(cfgQosId),
    .cfgQosTimeout(cfgQosTimeout), .expired(expired), .entryChip(entryChip),
    .issCmd(issCmd)
  );

  assign issId    = issCmd.id;
  assign issAddr  = issCmd.addr;
  assign issWrite = issCmd.write;
  assign issChip  = issCmd.chip;
endmodule

// File: tb/cmdq_sched_tb_top.sv
module cmdq_sched_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0, rstN = 1'b0;
  logic [11:0] cfgDefaultTimeout = 12'hFFF;
  logic [1:0]  cfgQosEn = '0;
  logic [7:0]  cfgQosId = '0;
  logic [23:0] cfgQosTimeout = '0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqChip = 1'b0, issReady = 1'b0;
  logic [3:0]  reqId = '0;
  logic [15:0] reqAddr = '0;
  logic        reqReady, issValid, issWrite, issChip, chip0Empty, chip1Empty;
  logic [3:0]  issId;
  logic [15:0] issAddr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdq_sched dut_i (
    .clk(clk), .rstN(rstN), .cfgDefaultTimeout(cfgDefaultTimeout),
    .cfgQosEn(cfgQosEn), .cfgQosId(cfgQosId), .cfgQosTimeout(cfgQosTimeout),
    .reqValid(reqValid), .reqReady(reqReady), .reqId(reqId), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqChip(reqChip), .issValid(issValid),
    .issReady(issReady), .issId(issId), .issAddr(issAddr), .issWrite(issWrite),
    .issChip(issChip), .chip0Empty(chip0Empty), .chip1Empty(chip1Empty)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(int id, int addr, bit wr, bit chip);
    reqValid = 1'b1; reqId = 4'(id); reqAddr = 16'(addr);
    reqWrite = wr; reqChip = chip;
    chk("R2 ready at push", int'(reqReady), 1);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic pop(string tag, int id, int addr, bit wr, bit chip);
    chk({tag, " valid"}, int'(issValid), 1);
    chk({tag, " id"}, int'(issId), id);
    chk({tag, " addr"}, int'(issAddr), addr);
    chk({tag, " write"}, int'(issWrite), int'(wr));
    chk({tag, " chip"}, int'(issChip), int'(chip));
    issReady = 1'b1;
    @(negedge clk);
    issReady = 1'b0;
  endtask

  task automatic drain();
    issReady = 1'b1;
    for (int k = 0; k < 20 && issValid; k++) @(negedge clk);
    issReady = 1'b0;
    cfgQosEn = '0;
  endtask

  task automatic t_reset();
    chk("R1 reqReady", int'(reqReady), 1);
    chk("R1 issValid", int'(issValid), 0);
    chk("R1 chip0Empty", int'(chip0Empty), 1);
    chk("R1 chip1Empty", int'(chip1Empty), 1);
  endtask

  task automatic t_order();
    cfgDefaultTimeout = 12'd500;
    push(4, 16'h1234, 1'b0, 1'b0);
    push(5, 16'h00FF, 1'b1, 1'b1);
    push(6, 16'hBEEF, 1'b0, 1'b1);
    waitN(3);
    chk("R7 held while not ready", int'(issId), 4);
    pop("R6 first", 4, 16'h1234, 1'b0, 1'b0);
    // accept and issue on the same edge
    chk("R6 second shown", int'(issId), 5);
    reqValid = 1'b1; reqId = 4'd7; reqAddr = 16'h0777; reqWrite = 1'b1; reqChip = 1'b0;
    issReady = 1'b1;
    @(negedge clk);
    reqValid = 1'b0; issReady = 1'b0;
    pop("R2 same-edge then R6", 6, 16'hBEEF, 1'b0, 1'b1);
    pop("R2 same-edge accepted", 7, 16'h0777, 1'b1, 1'b0);
    chk("R7 empty after pops", int'(issValid), 0);
  endtask

  task automatic t_full();
    cfgDefaultTimeout = 12'd500;
    for (int k = 0; k < 8; k++) push(k, k * 16, 1'b0, 1'b0);
    chk("R2 full ready low", int'(reqReady), 0);
    reqValid = 1'b1; reqId = 4'd15;
    waitN(3);
    reqValid = 1'b0;
    for (int k = 0; k < 8; k++) pop("R2 full drain", k, k * 16, 1'b0, 1'b0);
    chk("R2 stalled request dropped", int'(issValid), 0);
  endtask

  task automatic t_qos();
    cfgDefaultTimeout = 12'd40;
    cfgQosId = 8'h03; cfgQosTimeout = {12'd0, 12'd2}; cfgQosEn = 2'b01;
    push(1, 1, 1'b1, 1'b0); push(3, 2, 1'b0, 1'b0);
    waitN(8);
    chk("R3 slot0 match short timeout", int'(issId), 3);
    drain();
    cfgQosId = 8'h55; cfgQosTimeout = {12'd2, 12'd40}; cfgQosEn = 2'b11;
    push(1, 1, 1'b1, 1'b0); push(5, 2, 1'b0, 1'b0);
    waitN(8);
    chk("R3 slot0 wins over slot1", int'(issId), 1);
    drain();
    cfgQosId = 8'h06; cfgQosTimeout = {12'd0, 12'd2}; cfgQosEn = 2'b01;
    push(1, 1, 1'b0, 1'b0); push(6, 2, 1'b1, 1'b0);
    waitN(8);
    chk("R3 write ignores QoS", int'(issId), 1);
    drain();
    cfgQosId = 8'h70; cfgQosTimeout = {12'd2, 12'd0}; cfgQosEn = 2'b10;
    push(1, 1, 1'b1, 1'b0); push(7, 2, 1'b0, 1'b0);
    waitN(8);
    chk("R3 slot1 match", int'(issId), 7);
    drain();
  endtask

  task automatic t_timer();
    cfgDefaultTimeout = 12'd50;
    push(1, 0, 1'b1, 1'b0);
    cfgDefaultTimeout = 12'd3;
    push(2, 0, 1'b1, 1'b0);
    waitN(2);
    chk("R4 not yet expired after 2 edges", int'(issId), 1);
    waitN(1);
    chk("R4 expired after 3 edges", int'(issId), 2);
    waitN(20);
    chk("R4 holds at zero", int'(issId), 2);
    drain();
  endtask

  task automatic t_expOrder();
    cfgDefaultTimeout = 12'd60;
    push(1, 16'h10, 1'b0, 1'b0);
    cfgDefaultTimeout = 12'd2;
    push(2, 16'h20, 1'b0, 1'b1);
    push(3, 16'h30, 1'b1, 1'b0);
    waitN(10);
    pop("R5 oldest expired", 2, 16'h20, 1'b0, 1'b1);
    pop("R5 next expired", 3, 16'h30, 1'b1, 1'b0);
    pop("R6 remaining", 1, 16'h10, 1'b0, 1'b0);
  endtask

  task automatic t_chip();
    cfgDefaultTimeout = 12'd500;
    push(1, 0, 1'b0, 1'b1);
    chk("R8 chip0 empty", int'(chip0Empty), 1);
    chk("R8 chip1 busy", int'(chip1Empty), 0);
    push(2, 0, 1'b0, 1'b0);
    chk("R8 chip0 busy", int'(chip0Empty), 0);
    pop("R8 pop chip1", 1, 0, 1'b0, 1'b1);
    chk("R8 chip1 empty again", int'(chip1Empty), 1);
    chk("R8 chip0 still busy", int'(chip0Empty), 0);
    drain();
  endtask

  task automatic t_starve();
    int issuedAt;
    bit hs;
    issuedAt = -1;
    cfgDefaultTimeout = 12'd200;
    cfgQosId = 8'h09; cfgQosTimeout = {12'd0, 12'd3}; cfgQosEn = 2'b01;
    for (int k = 1; k < 8; k++) push(k, k, 1'b0, 1'b0);
    push(9, 16'h0999, 1'b0, 1'b1);
    for (int k = 1; k <= 20; k++) begin
      issReady = 1'b1;
      reqValid = 1'b1; reqId = 4'd2; reqWrite = 1'b0; reqChip = 1'b0;
      hs = issValid && (issId == 4'd9);
      @(negedge clk);
      if (hs) begin issuedAt = k; break; end
    end
    reqValid = 1'b0; issReady = 1'b0;
    chk("R9 issued at T+1 edges", issuedAt, 4);
    drain();
  endtask

  initial begin
    waitN(3);
    t_reset();
    rstN = 1'b1;
    waitN(1);
    t_reset();
    t_order();
    t_full();
    t_qos();
    t_timer();
    t_expOrder();
    t_chip();
    t_starve();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule